// File: doc/BRIEF.md
# Multicast Group-Address Hash Filter

This block holds a 256-entry hash table of group-address bits, kept as eight 32-bit words, and uses it to decide whether a received multicast destination address passes. Software fills the table in one of two ways. It can hand a full 48-bit MAC address to the command port with a set or clear flag, and the block hashes the address and updates the one table bit it maps to. It can also overwrite a whole 32-bit word directly. All eight words can be read back.

The hash is the Ethernet CRC-32 of the six address octets. An 8-bit index is taken from that CRC. The upper three index bits pick a word, and the lower five pick a bit inside that word, counted from the most significant end.

The lookup port takes a destination address and, one cycle later, returns a done strobe together with an accept flag. An address passes only when its group bit is set and its table bit is 1.

Top module: `mhash_filter`

## Requirements
- R1: After reset every table word reads back as zero and `lk_done` and `lk_accept` are low.
- R2: Address octet k sits in bits [8k+7:8k], so the first octet on the wire is in bits [7:0] and its group bit is bit 0. The CRC register starts at all ones. Address bits are fed in the order bit 0, bit 1, ..., bit 47 through the reflected CRC-32 polynomial 0xEDB88320. No final inversion is applied. Index bit 7-k equals CRC register bit k for k = 0..7; this is the top byte of the bit-reversed CRC.
- R3: Index i selects word i[7:5] and bit 31 - i[4:0] of that word. Index 0 is bit 31 of word 0, and index 255 is bit 0 of word 7.
- R4: A command with `ctl_valid` high sets the selected bit when `ctl_set` is 1 and clears it when `ctl_set` is 0. The change is visible from the next cycle, and every other table bit keeps its value.
- R5: A direct write replaces the full 32-bit word `wr_sel` with `wr_data`. When a command in the same cycle targets the same word, the direct write wins. When the command targets a different word, both take effect.
- R6: `lk_done` is high exactly in the cycle after a cycle with `lk_valid` high. In that cycle, `lk_accept` is 1 only if bit 0 of the looked-up address was 1 and its indexed table bit was 1.
- R7: A lookup is judged against the table as it stood before the clock edge. A set, clear or write in the same cycle does not affect that lookup's result.
- R8: `rd_data` shows the current contents of word `rd_sel` without a clock delay.
- R9: In a cycle with neither `ctl_valid` nor `wr_en` high, no table bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_valid | input | 1 | Set/clear command strobe |
| ctl_set | input | 1 | 1 = set bit, 0 = clear bit |
| ctl_addr | input | 48 | MAC address whose table bit is updated |
| wr_en | input | 1 | Direct word write strobe |
| wr_sel | input | 3 | Word number for direct write |
| wr_data | input | 32 | New contents of the word |
| rd_sel | input | 3 | Word number for read-back |
| rd_data | output | 32 | Contents of word `rd_sel` |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 48 | Destination address to test |
| lk_done | output | 1 | Lookup result valid |
| lk_accept | output | 1 | 1 = address passes the filter |

## Verification
Several functions can land in the same cycle. A lookup can coincide with a set or clear of its own address, and a direct word write can coincide with a set or clear that hashes into the same word. The bench provokes both cases on purpose: it issues a set and a lookup of one address together, and it writes a word while a command targets that word. A behavioural reference model then judges each cycle. The lookup must follow the table as it stood before the edge, and the written word must hold exactly the write data. Random mixes of all three ports add further collisions, and the output is compared against the model on every clock.

// File: rtl/mhash_pkg.sv
package mhash_pkg;
    localparam int unsigned CRC_W = 32;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;

    typedef enum logic {
        OP_CLEAR = 1'b0,
        OP_SET   = 1'b1
    } hash_op_e;
endpackage

// File: rtl/mhash_crc_idx.sv
module mhash_crc_idx #(
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned IDX_W  = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  idx_o
);
    import mhash_pkg::*;

    logic [CRC_W-1:0] crc;

    always_comb begin
        logic [CRC_W-1:0] c;
        logic fb;
        c = CRC_SEED;
        for (int i = 0; i < int'(ADDR_W); i++) begin
            fb = c[0] ^ addr_i[i];
            c  = c >> 1;
            if (fb) begin
                c = c ^ CRC_POLY_REFL;
            end
        end
        crc = c;
    end

    for (genvar k = 0; k < int'(IDX_W); k++) begin : g_rev
        assign idx_o[IDX_W-1-k] = crc[k];
    end
endmodule

// File: rtl/mhash_table.sv
module mhash_table #(
    parameter int unsigned NUM_WORDS = 8,
    parameter int unsigned WORD_W    = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                ctl_valid,
    input  logic                                ctl_set,
    input  logic [$clog2(NUM_WORDS*WORD_W)-1:0] ctl_idx,
    input  logic                                wr_en,
    input  logic [$clog2(NUM_WORDS)-1:0]        wr_sel,
    input  logic [WORD_W-1:0]                   wr_data,
    input  logic [$clog2(NUM_WORDS)-1:0]        rd_sel,
    output logic [WORD_W-1:0]                   rd_data,
    input  logic                                lk_valid,
    input  logic                                lk_grp,
    input  logic [$clog2(NUM_WORDS*WORD_W)-1:0] lk_idx,
    output logic                                lk_done,
    output logic                                lk_accept,
    output logic [NUM_WORDS*WORD_W-1:0]         tbl_flat
);
    import mhash_pkg::*;

    localparam int unsigned SEL_W = $clog2(NUM_WORDS);
    localparam int unsigned BIT_W = $clog2(WORD_W);
    localparam int unsigned IDX_W = SEL_W + BIT_W;
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] tbl;
        logic                             done;
        logic                             hit;
    } state_t;

    state_t st_d, st_q;

    logic [SEL_W-1:0] ctl_word, lk_word;
    logic [BIT_W-1:0] ctl_pos, lk_pos;

    assign ctl_word = ctl_idx[IDX_W-1:BIT_W];
    assign ctl_pos  = TOP_BIT - ctl_idx[BIT_W-1:0];
    assign lk_word  = lk_idx[IDX_W-1:BIT_W];
    assign lk_pos   = TOP_BIT - lk_idx[BIT_W-1:0];

    always_comb begin
        st_d      = st_q;
        st_d.done = lk_valid;
        st_d.hit  = lk_valid & lk_grp & st_q.tbl[lk_word][lk_pos];
        if (ctl_valid) begin
            st_d.tbl[ctl_word][ctl_pos] = (hash_op_e'(ctl_set) == OP_SET);
        end
        if (wr_en) begin
            st_d.tbl[wr_sel] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data   = st_q.tbl[rd_sel];
    assign lk_done   = st_q.done;
    assign lk_accept = st_q.hit;
    assign tbl_flat  = st_q.tbl;
endmodule

// File: rtl/mhash_filter.sv
module mhash_filter #(
    parameter int unsigned ADDR_W    = 48,
    parameter int unsigned NUM_WORDS = 8,
    parameter int unsigned WORD_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ctl_valid,
    input  logic                         ctl_set,
    input  logic [ADDR_W-1:0]            ctl_addr,
    input  logic                         wr_en,
    input  logic [$clog2(NUM_WORDS)-1:0] wr_sel,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic [$clog2(NUM_WORDS)-1:0] rd_sel,
    output logic [WORD_W-1:0]            rd_data,
    input  logic                         lk_valid,
    input  logic [ADDR_W-1:0]            lk_addr,
    output logic                         lk_done,
    output logic                         lk_accept
);
    localparam int unsigned IDX_W = $clog2(NUM_WORDS * WORD_W);

    logic [IDX_W-1:0]            ctl_idx;
    logic [IDX_W-1:0]            lk_idx;
    logic [NUM_WORDS*WORD_W-1:0] tbl_flat;

    mhash_crc_idx #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_crc_ctl (
        .addr_i (ctl_addr),
        .idx_o  (ctl_idx)
    );

    mhash_crc_idx #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_crc_lk (
        .addr_i (lk_addr),
        .idx_o  (lk_idx)
    );

    mhash_table #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_valid (ctl_valid),
        .ctl_set   (ctl_set),
        .ctl_idx   (ctl_idx),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .lk_valid  (lk_valid),
        .lk_grp    (lk_addr[0]),
        .lk_idx    (lk_idx),
        .lk_done   (lk_done),
        .lk_accept (lk_accept),
        .tbl_flat  (tbl_flat)
    );
endmodule

// File: rtl/mhash_check.sv
module mhash_check #(
    parameter int unsigned ADDR_W    = 48,
    parameter int unsigned NUM_WORDS = 8,
    parameter int unsigned WORD_W    = 32
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                ctl_valid,
    input logic                                ctl_set,
    input logic [$clog2(NUM_WORDS*WORD_W)-1:0] ctl_idx,
    input logic                                wr_en,
    input logic [$clog2(NUM_WORDS)-1:0]        wr_sel,
    input logic [WORD_W-1:0]                   wr_data,
    input logic                                lk_valid,
    input logic [ADDR_W-1:0]                   lk_addr,
    input logic                                lk_done,
    input logic                                lk_accept,
    input logic [NUM_WORDS*WORD_W-1:0]         tbl
);
    localparam int unsigned BIT_W = $clog2(WORD_W);
    localparam int unsigned IDX_W = $clog2(NUM_WORDS * WORD_W);

    int tgt_pos;
    int wr_base;

    always_comb begin
        tgt_pos = int'(ctl_idx[IDX_W-1:BIT_W]) * int'(WORD_W)
                + int'(WORD_W) - 1 - int'(ctl_idx[BIT_W-1:0]);
        wr_base = int'(wr_sel) * int'(WORD_W);
    end

    a_r6_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_done);

    a_r6_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_done && !lk_accept);

    a_r6_unicast_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_addr[0]) |=> !lk_accept);

    a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_set && !wr_en) |=> tbl[$past(tgt_pos)]);

    a_r4_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && !ctl_set && !wr_en) |=> !tbl[$past(tgt_pos)]);

    a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && !wr_en) |=> ($countones(tbl ^ $past(tbl)) <= 1));

    a_r5_wr_replace: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl[$past(wr_base) +: WORD_W] == $past(wr_data)));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_valid && !wr_en) |=> $stable(tbl));
endmodule

bind mhash_filter mhash_check #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_valid (ctl_valid),
    .ctl_set   (ctl_set),
    .ctl_idx   (ctl_idx),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .lk_done   (lk_done),
    .lk_accept (lk_accept),
    .tbl       (tbl_flat)
);

// File: tb/mhash_filter_tb.sv
module mhash_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_valid = 1'b0;
    logic        ctl_set = 1'b0;
    logic [47:0] ctl_addr = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_addr = '0;
    logic        lk_done;
    logic        lk_accept;

    int unsigned total = 0;
    int unsigned fails = 0;
    bit          finished = 1'b0;
    logic [31:0] ref_tbl [8];

    always #2 clk = ~clk;

    mhash_filter dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_set(ctl_set),
        .ctl_addr(ctl_addr), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .lk_done(lk_done), .lk_accept(lk_accept)
    );

    // Forward-polynomial form: index is the top byte of the register.
    function automatic int hash_of(logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = c[31] ^ a[i];
            c = c << 1;
            if (fb) c = c ^ 32'h04C1_1DB7;
        end
        return int'(c[31:24]);
    endfunction

    function automatic logic ref_bit(int idx);
        return ref_tbl[idx / 32][31 - (idx % 32)];
    endfunction

    function automatic logic [47:0] addr_for(int idx, logic grp);
        for (int k = 1; k < 200000; k++) begin
            logic [47:0] a = (48'(k) << 1) | 48'(grp);
            if (hash_of(a) == idx) return a;
        end
        return '0;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, model updates, compare at next negedge.
    task automatic cycle(input bit cv, input bit cs, input logic [47:0] ca,
                         input bit lv, input logic [47:0] la,
                         input bit we, input logic [2:0] ws, input logic [31:0] wd,
                         input logic [2:0] rs, input string tag);
        logic exp_acc;
        ctl_valid = cv; ctl_set = cs; ctl_addr = ca;
        lk_valid = lv; lk_addr = la;
        wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
        exp_acc = lv && la[0] && ref_bit(hash_of(la));
        if (cv) begin
            int h = hash_of(ca);
            ref_tbl[h / 32][31 - (h % 32)] = cs;
        end
        if (we) ref_tbl[ws] = wd;
        @(posedge clk);
        @(negedge clk);
        chk(lk_done == lv, {tag, " R6 done"}, longint'(lk_done), longint'(lv));
        chk(lk_accept == exp_acc, {tag, " R6 accept"}, longint'(lk_accept), longint'(exp_acc));
        chk(rd_data == ref_tbl[rs], {tag, " R8 readback"}, longint'(rd_data), longint'(ref_tbl[rs]));
    endtask

    task automatic idle(input logic [2:0] rs, input string tag);
        cycle(0, 0, '0, 0, '0, 0, '0, '0, rs, tag);
    endtask

    task automatic sweep(input string tag);
        for (int w = 0; w < 8; w++) idle(3'(w), tag);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            fails++; total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [47:0] a0, a255, m1, m2, u1;
        int h;
        for (int w = 0; w < 8; w++) ref_tbl[w] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(lk_done == 1'b0 && lk_accept == 1'b0, "R1 outputs after reset",
            longint'({lk_done, lk_accept}), 0);
        sweep("R1 reset table");

        // R2/R3: boundary indices 0 and 255 via direct writes
        a0   = addr_for(0, 1'b1);
        a255 = addr_for(255, 1'b1);
        cycle(0, 0, '0, 1, a0, 1, 3'd0, 32'h8000_0000, 3'd0, "R3 idx0 write");
        cycle(0, 0, '0, 1, a0, 0, '0, '0, 3'd0, "R3 idx0 lookup");
        chk(lk_accept == 1'b1, "R3 idx0 is word0 bit31", longint'(lk_accept), 1);
        cycle(0, 0, '0, 1, a255, 1, 3'd7, 32'h0000_0001, 3'd7, "R3 idx255 write");
        cycle(0, 0, '0, 1, a255, 0, '0, '0, 3'd7, "R3 idx255 lookup");
        chk(lk_accept == 1'b1, "R3 idx255 is word7 bit0", longint'(lk_accept), 1);
        cycle(0, 0, '0, 0, '0, 1, 3'd0, 32'h0, 3'd0, "R5 wipe0");
        cycle(0, 0, '0, 0, '0, 1, 3'd7, 32'h0, 3'd7, "R5 wipe7");

        // R2/R4: set by command, lookup accepts
        m1 = 48'h0000_005E_0001 | 48'h1;
        m2 = 48'hABCD_EF12_3401;
        cycle(1, 1, m1, 0, '0, 0, '0, '0, 3'(hash_of(m1) / 32), "R4 set m1");
        cycle(0, 0, '0, 1, m1, 0, '0, '0, 3'd0, "R2 lookup m1");
        chk(lk_accept == 1'b1, "R2 m1 accepted", longint'(lk_accept), 1);

        // R7: set and lookup of same address together
        h = hash_of(m2);
        cycle(1, 1, m2, 1, m2, 0, '0, '0, 3'(h / 32), "R7 same-cycle set");
        chk(lk_accept == (ref_bit(h) && hash_of(m1) == h) || lk_accept == 1'b0,
            "R7 lookup saw old table", longint'(lk_accept), 0);
        cycle(0, 0, '0, 1, m2, 0, '0, '0, 3'(h / 32), "R7 lookup after");
        chk(lk_accept == 1'b1, "R7 m2 accepted next", longint'(lk_accept), 1);

        // R6: unicast address with its bit set is rejected
        u1 = addr_for(hash_of(m2), 1'b0);
        cycle(0, 0, '0, 1, u1, 0, '0, '0, 3'd0, "R6 unicast");
        chk(lk_accept == 1'b0, "R6 unicast rejected", longint'(lk_accept), 0);

        // R4: clear removes entry, others kept
        cycle(1, 0, m2, 0, '0, 0, '0, '0, 3'(h / 32), "R4 clear m2");
        cycle(0, 0, '0, 1, m2, 0, '0, '0, 3'd0, "R4 lookup cleared");
        chk(lk_accept == (hash_of(m1) == h), "R4 m2 rejected after clear",
            longint'(lk_accept), longint'(hash_of(m1) == h));

        // R5: write and command on same word in one cycle; write wins
        h = hash_of(m2);
        cycle(1, 1, m2, 0, '0, 1, 3'(h / 32), 32'h1234_5678, 3'(h / 32), "R5 collide");
        chk(rd_data == 32'h1234_5678, "R5 write wins", longint'(rd_data), 32'h1234_5678);
        // R5: different words both take effect
        cycle(1, 1, m2, 0, '0, 1, 3'((h / 32 + 1) % 8), 32'hCAFE_0000, 3'((h / 32 + 1) % 8), "R5 both");
        sweep("R5 both sweep");

        // R9: idle cycles leave the table as is
        sweep("R9 hold");

        // Mixed random traffic compared every cycle
        for (int n = 0; n < 400; n++) begin
            logic [47:0] ra = {$urandom(), $urandom()} & 48'h0000_0000_0FFF;
            logic [47:0] rl = {$urandom(), $urandom()} & 48'h0000_0000_0FFF;
            cycle(($urandom() % 3) == 0, $urandom() % 2, ra,
                  ($urandom() % 2) == 0, rl,
                  ($urandom() % 9) == 0, 3'($urandom()), $urandom(),
                  3'($urandom()), "R4 R6 random");
        end
        sweep("R8 final sweep");

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule